// File: doc/BRIEF.md
# Repeater Port Auto-Partition Controller

This block decides, for each port of a five-port Ethernet repeater, whether that port is isolated from the rest of the network. Ports 0 to 3 are the twisted-pair ports. Port 4 is the attachment-unit port. Every port presents three levels on each clock: activity, collision and transmit direction. One clock is one bit time. From these levels the block tracks packets and the collisions inside them. It isolates a port that keeps colliding, or that holds a single collision for too long. It reconnects the port when a long, collision-free packet arrives that meets the active reconnection rule.

Two reconnection rules exist. Under the normal rule, any long clean packet reconnects the port, whether the port received it or sent it. Under the alternate rule, only a long clean packet that the repeater sends out of the isolated port reconnects it. One select bit sets the rule for all twisted-pair ports together. A second select bit sets it for the attachment port. A per-port enable level lets control logic take a port out of service: a disabled port is held in a cleared state.

While a port is isolated, it keeps watching its own activity and collisions, so that a reconnecting packet can be seen. The repeater core uses the registered isolation flags to stop forwarding from isolated ports and to drive the per-port status indicators.

Top module: `rpt_partition_ctl`

## Requirements
- R1: After reset, every `port_part` bit is 0.
- R2: A port becomes isolated at the end of its 32nd consecutive packet that had a collision. After 31 such packets it is not isolated. A packet is one unbroken run of cycles with `port_act` high. A collision counts only while `port_act` is high. The new flag is visible on the second clock edge after the last active cycle.
- R3: A packet that ends without any collision clears the consecutive-collision count, whatever its length.
- R4: A port becomes isolated as soon as `port_col` has been high together with `port_act` for 1025 consecutive cycles. This happens in the middle of the packet, one edge after the 1025th such cycle. 1024 cycles are not enough.
- R5: Under the normal rule (select bit 0), an isolated port is reconnected by a collision-free packet of more than 512 active cycles, received or sent. A packet of exactly 512 cycles does not reconnect it.
- R6: Under the alternate rule (select bit 1), only a collision-free packet of more than 512 cycles reconnects the port, and only if `port_tx` was 1 on the first active cycle of that packet. A received packet (`port_tx` 0 on its first cycle) leaves the port isolated.
- R7: `alt_tp_sel` sets the rule for ports 0 to 3. `alt_aui_sel` sets the rule for port 4. Neither bit affects the other group.
- R8: While `port_en` of a port is 0, its `port_part` is 0 and its collision count is held at zero. After the port is enabled again, it starts unpartitioned with a count of zero.
- R9: An isolated port keeps tracking packets. A long packet that contains a collision does not reconnect it, and it stays isolated.
- R10: Each port's state depends only on that port's own inputs and its group's select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 5 | Per-port enable level, 1 = in service |
| port_act | input | 5 | Per-port activity level, 1 = packet in progress |
| port_col | input | 5 | Per-port collision level |
| port_tx | input | 5 | Per-port direction, 1 = repeater is sending on the port |
| alt_tp_sel | input | 1 | Rule select for ports 0 to 3, 1 = alternate rule |
| alt_aui_sel | input | 1 | Rule select for port 4, 1 = alternate rule |
| port_part | output | 5 | Per-port isolation flag |

## Verification
The hardest states to reach from the ports are the thresholds themselves. These are the 32nd collided packet after a run that was broken by a single clean packet, and the exact cycle in which a 1025-cycle collision isolates a port while the packet is still active. Directed sequences build the collision run packet by packet, including a clean packet in the middle. They also hold the collision level for 1024 and then 1025 cycles and sample the flag in the cycle before and the cycle after the limit. Random packets then use lengths close to 512 cycles and collision bursts long enough to cross the count limit. They also change the rule bits and briefly disable ports. A bench model predicts the flags of all five ports after every packet.

// File: rtl/rpt_part_pkg.sv
package rpt_part_pkg;

    typedef enum logic {
        RULE_NORMAL = 1'b0,
        RULE_ALT    = 1'b1
    } recon_rule_e;

    localparam int DEF_NUM_TP       = 4;
    localparam int DEF_COL_LIMIT    = 31;
    localparam int DEF_LONG_COL     = 1024;
    localparam int DEF_RECON_LEN    = 512;

endpackage

// File: rtl/rpt_part_rule_map.sv
module rpt_part_rule_map #(
    parameter int NUM_TP    = rpt_part_pkg::DEF_NUM_TP,
    parameter int NUM_PORTS = NUM_TP + 1
) (
    input  logic                      alt_tp_sel,
    input  logic                      alt_aui_sel,
    output rpt_part_pkg::recon_rule_e rule [NUM_PORTS]
);
    import rpt_part_pkg::*;

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_rule
        if (gi < NUM_TP) begin : g_tp
            assign rule[gi] = alt_tp_sel ? RULE_ALT : RULE_NORMAL;
        end else begin : g_aui
            assign rule[gi] = alt_aui_sel ? RULE_ALT : RULE_NORMAL;
        end
    end

endmodule

// File: rtl/rpt_part_port.sv
module rpt_part_port #(
    parameter int COL_LIMIT = rpt_part_pkg::DEF_COL_LIMIT,
    parameter int LONG_COL  = rpt_part_pkg::DEF_LONG_COL,
    parameter int RECON_LEN = rpt_part_pkg::DEF_RECON_LEN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      act,
    input  logic                      col,
    input  logic                      tx,
    input  rpt_part_pkg::recon_rule_e rule,
    output logic                      part
);
    import rpt_part_pkg::*;

    localparam int CNT_SAT = COL_LIMIT + 1;
    localparam int CW      = $clog2(CNT_SAT + 1);
    localparam int LEN_SAT = RECON_LEN + 1;
    localparam int LW      = $clog2(LEN_SAT + 1);
    localparam int CL_SAT  = LONG_COL + 1;
    localparam int KW      = $clog2(CL_SAT + 1);

    typedef struct packed {
        logic          part;
        logic [CW-1:0] cnt;
        logic [LW-1:0] len;
        logic [KW-1:0] clen;
        logic          had_col;
        logic          is_tx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (act) begin
            // packet in progress: measure length, collision run and direction
            if (st_q.len != LW'(LEN_SAT)) st_d.len = st_q.len + LW'(1);
            if (st_q.len == '0) st_d.is_tx = tx;
            if (col) begin
                st_d.had_col = 1'b1;
                if (st_q.clen != KW'(CL_SAT)) st_d.clen = st_q.clen + KW'(1);
                if (st_d.clen == KW'(CL_SAT)) st_d.part = 1'b1;
            end else begin
                st_d.clen = '0;
            end
        end else begin
            st_d.clen = '0;
            if (st_q.len != '0) begin
                // first idle cycle after a packet: judge the packet
                if (st_q.had_col) begin
                    if (st_q.cnt != CW'(CNT_SAT)) st_d.cnt = st_q.cnt + CW'(1);
                    if (st_d.cnt == CW'(CNT_SAT)) st_d.part = 1'b1;
                end else begin
                    st_d.cnt = '0;
                    if (st_q.len == LW'(LEN_SAT) &&
                        (rule == RULE_NORMAL || st_q.is_tx))
                        st_d.part = 1'b0;
                end
                st_d.len     = '0;
                st_d.had_col = 1'b0;
                st_d.is_tx   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign part = st_q.part;

endmodule

// File: rtl/rpt_partition_ctl.sv
module rpt_partition_ctl #(
    parameter int NUM_TP    = rpt_part_pkg::DEF_NUM_TP,
    parameter int NUM_PORTS = NUM_TP + 1,
    parameter int COL_LIMIT = rpt_part_pkg::DEF_COL_LIMIT,
    parameter int LONG_COL  = rpt_part_pkg::DEF_LONG_COL,
    parameter int RECON_LEN = rpt_part_pkg::DEF_RECON_LEN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_en,
    input  logic [NUM_PORTS-1:0] port_act,
    input  logic [NUM_PORTS-1:0] port_col,
    input  logic [NUM_PORTS-1:0] port_tx,
    input  logic                 alt_tp_sel,
    input  logic                 alt_aui_sel,
    output logic [NUM_PORTS-1:0] port_part
);
    import rpt_part_pkg::*;

    recon_rule_e rule [NUM_PORTS];

    rpt_part_rule_map #(
        .NUM_TP   (NUM_TP),
        .NUM_PORTS(NUM_PORTS)
    ) rule_map_i (
        .alt_tp_sel (alt_tp_sel),
        .alt_aui_sel(alt_aui_sel),
        .rule       (rule)
    );

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        rpt_part_port #(
            .COL_LIMIT(COL_LIMIT),
            .LONG_COL (LONG_COL),
            .RECON_LEN(RECON_LEN)
        ) port_i (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (port_en[gp]),
            .act  (port_act[gp]),
            .col  (port_col[gp]),
            .tx   (port_tx[gp]),
            .rule (rule[gp]),
            .part (port_part[gp])
        );
    end

endmodule

// File: rtl/rpt_part_chk.sv
module rpt_part_chk #(
    parameter int NP = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] port_en,
    input logic [NP-1:0] port_act,
    input logic [NP-1:0] port_col,
    input logic [NP-1:0] port_part
);
    for (genvar gc = 0; gc < NP; gc++) begin : g_chk
        // R8: a disabled port is never flagged on the next cycle
        p_off_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !port_en[gc] |=> !port_part[gc]);

        // R8: isolation can only start while the port is enabled
        p_rise_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_part[gc]) |-> $past(port_en[gc]));

        // R2 / R4: isolation starts at a packet end or during a collision
        p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(port_part[gc]) |-> ($past(port_col[gc]) || !$past(port_act[gc])));

        // R5: reconnection happens only at a packet end or by disabling
        p_fall_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(port_part[gc]) |-> (!$past(port_en[gc]) || !$past(port_act[gc])));
    end
endmodule

bind rpt_partition_ctl rpt_part_chk #(.NP(NUM_PORTS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .port_act (port_act),
    .port_col (port_col),
    .port_part(port_part)
);

// File: tb/rpt_partition_ctl_tb_top.sv
module rpt_partition_ctl_tb_top;
    localparam int NTP   = 4;
    localparam int NP    = NTP + 1;
    localparam int LIMIT = 31;
    localparam int LONG  = 1024;
    localparam int RECON = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] port_en = '1;
    logic [NP-1:0] port_act = '0;
    logic [NP-1:0] port_col = '0;
    logic [NP-1:0] port_tx = '0;
    logic          alt_tp_sel = 1'b0;
    logic          alt_aui_sel = 1'b0;
    logic [NP-1:0] port_part;

    int n_chk = 0;
    int n_bad = 0;
    bit m_part [NP];
    int m_cnt  [NP];
    bit done = 1'b0;

    always #5 clk = ~clk;

    rpt_partition_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .port_act(port_act),
        .port_col(port_col), .port_tx(port_tx), .alt_tp_sel(alt_tp_sel),
        .alt_aui_sel(alt_aui_sel), .port_part(port_part)
    );

    // Expected state after one packet, from the requirements
    function automatic void model_pkt(int p, int len, int colc, bit txb);
        bit a = (p < NTP) ? alt_tp_sel : alt_aui_sel;
        if (colc > LONG) m_part[p] = 1'b1;
        if (colc > 0) begin
            if (m_cnt[p] <= LIMIT) m_cnt[p]++;
            if (m_cnt[p] > LIMIT) m_part[p] = 1'b1;
        end else begin
            m_cnt[p] = 0;
            if (len > RECON && (!a || txb)) m_part[p] = 1'b0;
        end
    endfunction

    function automatic logic [NP-1:0] model_vec();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = m_part[i];
        return v;
    endfunction

    task automatic check_vec(string req);
        n_chk++;
        if (port_part !== model_vec()) begin
            n_bad++;
            $display("FAIL %s port_part actual=%b expected=%b", req, port_part, model_vec());
        end
    endtask

    task automatic check_bit(int p, bit exp, string req);
        n_chk++;
        if (port_part[p] !== exp) begin
            n_bad++;
            $display("FAIL %s port%0d part actual=%b expected=%b", req, p, port_part[p], exp);
        end
    endtask

    // Drives one packet on port p; returns at the negedge after the end is judged
    task automatic send_pkt(int p, int len, int colc, bit txb);
        for (int k = 0; k < len; k++) begin
            port_act[p] = 1'b1;
            port_col[p] = (k < colc);
            port_tx[p]  = txb;
            @(negedge clk);
        end
        port_act[p] = 1'b0;
        port_col[p] = 1'b0;
        port_tx[p]  = 1'b0;
        @(negedge clk);
        model_pkt(p, len, colc, txb);
    endtask

    task automatic burst(int p, int n, string req);
        for (int i = 0; i < n; i++) send_pkt(p, 6, 2, 1'b0);
        check_vec(req);
    endtask

    task automatic cycle_en(int p);
        port_en[p] = 1'b0;
        @(negedge clk);
        m_part[p] = 1'b0;
        m_cnt[p]  = 0;
        check_bit(p, 1'b0, "R8 disabled");
        port_en[p] = 1'b1;
        @(negedge clk);
        check_bit(p, 1'b0, "R8 re-enabled");
    endtask

    initial begin
        for (int i = 0; i < NP; i++) begin m_part[i] = 0; m_cnt[i] = 0; end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_vec("R1 reset");

        // R2: 31 collided packets do not isolate, the 32nd does
        burst(1, 31, "R2 31 collisions");
        burst(1, 1, "R2 32nd collision");
        check_bit(1, 1'b1, "R2 isolated");

        // R9: collided long packet keeps it isolated
        send_pkt(1, 600, 1, 1'b0);
        check_bit(1, 1'b1, "R9 still isolated");

        // R5: 512 clean cycles not enough, 513 reconnect
        send_pkt(1, 512, 0, 1'b0);
        check_bit(1, 1'b1, "R5 512 no reconnect");
        send_pkt(1, 513, 0, 1'b0);
        check_bit(1, 1'b0, "R5 513 reconnect");

        // R3: a clean short packet breaks the collision run
        burst(2, 20, "R3 run");
        send_pkt(2, 5, 0, 1'b0);
        burst(2, 31, "R3 31 after clear");
        check_bit(2, 1'b0, "R3 not isolated");
        burst(2, 1, "R3 32nd");
        check_bit(2, 1'b1, "R3 isolated");

        // R6: alternate rule on the twisted-pair group
        alt_tp_sel = 1'b1;
        send_pkt(2, 600, 0, 1'b0);
        check_bit(2, 1'b1, "R6 received ignored");
        send_pkt(2, 600, 0, 1'b1);
        check_bit(2, 1'b0, "R6 sent reconnects");

        // R7: attachment port stays on normal rule while TP uses alternate
        burst(4, 32, "R7 aui isolate");
        burst(0, 32, "R7 tp isolate");
        send_pkt(4, 600, 0, 1'b0);
        check_bit(4, 1'b0, "R7 aui normal rule");
        send_pkt(0, 600, 0, 1'b0);
        check_bit(0, 1'b1, "R7 tp alt rule");
        alt_tp_sel = 1'b0; alt_aui_sel = 1'b1;
        burst(4, 32, "R7 aui isolate again");
        send_pkt(4, 600, 0, 1'b0);
        check_bit(4, 1'b1, "R7 aui alt rule");
        send_pkt(0, 600, 0, 1'b0);
        check_bit(0, 1'b0, "R7 tp normal rule");
        alt_aui_sel = 1'b0;

        // R4: long collision, exact cycle
        for (int k = 0; k < 1024; k++) begin
            port_act[3] = 1'b1; port_col[3] = 1'b1; @(negedge clk);
        end
        check_bit(3, 1'b0, "R4 1024 cycles");
        @(negedge clk);
        check_bit(3, 1'b1, "R4 1025 cycles");
        port_act[3] = 1'b0; port_col[3] = 1'b0;
        @(negedge clk);
        model_pkt(3, 1025, 1025, 1'b0);
        check_vec("R4 after packet");

        // R8: disable clears flag and count
        cycle_en(4);
        cycle_en(3);
        burst(3, 31, "R8 count cleared");
        check_bit(3, 1'b0, "R8 count cleared");
        send_pkt(3, 3, 0, 1'b0);

        // R10: random mixed traffic, all ports compared after each packet
        for (int it = 0; it < 220; it++) begin
            int p = $urandom_range(0, NP - 1);
            int r = $urandom_range(0, 9);
            int len = (r < 7) ? $urandom_range(2, 40) : $urandom_range(505, 530);
            int colc = ($urandom_range(0, 1) == 1) ? $urandom_range(1, 4) : 0;
            if ($urandom_range(0, 7) == 0) begin alt_tp_sel = $urandom_range(0, 1); alt_aui_sel = $urandom_range(0, 1); end
            if ($urandom_range(0, 19) == 0) cycle_en(p);
            else if ($urandom_range(0, 9) == 0) burst(p, 33, "R10 random burst");
            else begin
                send_pkt(p, len, colc, 1'($urandom_range(0, 1)));
                check_vec("R10 random");
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule